// File: doc/BRIEF.md
# Single-Precision Float to 32-bit Integer Converter

This unit takes a packed single-precision floating-point word and turns it into a 32-bit integer, either unsigned or two's-complement signed, as chosen per operation by a mode input. A 2-bit rounding-mode input picks how the discarded fractional bits are treated. A force-truncate input overrides that choice with round-toward-zero for the conversions that always chop. Every accepted operation gives one registered result one clock later, together with three flags: invalid operation, inexact result and denormal input.

Values too large for the target range saturate, and the limit depends on the sign and the mode. NaNs are handled separately for signed and unsigned results. Fractions smaller than one half in magnitude still respect the directed rounding modes. The unit is fully pipelined: it accepts a new operation on every cycle.

Top module: `f2i_convert`

## Requirements
- R1: Synchronous active-high reset clears `out_valid`, `out_int` and all flags to zero. Each cycle with `in_valid` high gives `out_valid` high in the next cycle. A cycle with `in_valid` low gives `out_valid` low in the next cycle.
- R2: `round_mode` encodes 0 = nearest with ties to even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero. When `force_trunc` is 1, toward-zero is used whatever `round_mode` holds.
- R3: For biased exponents 126 to 158, the integer part is the significand (implicit one included) shifted right. The bits shifted out form the remainder, which drives rounding. The integer part moves one step away from zero when the rounding mode calls for it. A nonzero remainder sets inexact unless invalid is raised for the same value.
- R4: Unsigned mode, biased exponent 159 or more (infinities included): the result is 0xFFFFFFFF for a positive value and 0 for a negative value, with invalid set.
- R5: Signed mode, biased exponent 159 or more (infinities included): the result is 0x7FFFFFFF for a positive value and 0x80000000 for a negative value, with invalid set.
- R6: A NaN gives 0 with invalid in signed mode. In unsigned mode the NaN's sign is ignored and the result is 0xFFFFFFFF with invalid.
- R7: Unsigned mode: a negative in-range value whose rounded magnitude is nonzero gives 0 with invalid and without inexact. A negative value that rounds to zero gives 0 with only inexact.
- R8: Signed mode: a rounded magnitude above 0x7FFFFFFF (positive) or above 0x80000000 (negative) is clamped to that limit with invalid. Exactly -2^31 converts to 0x80000000 with no flags.
- R9: Nonzero inputs with biased exponent below 126 set inexact. The result is 1 for a positive value under toward +infinity. A negative value under toward -infinity gives 0xFFFFFFFF in signed mode, and 0 with invalid in unsigned mode. All other cases give 0.
- R10: Positive and negative zero give 0 with no flags in every mode.
- R11: The denormal flag is set exactly when the input has exponent field 0 and a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_bits | input | 32 | Packed single-precision operand (sign 31, exponent 30:23, fraction 22:0) |
| to_signed | input | 1 | 1 = signed result, 0 = unsigned result |
| round_mode | input | 2 | Rounding mode, encoding in R2 |
| force_trunc | input | 1 | Override rounding with toward-zero |
| out_valid | output | 1 | Result registers updated from the previous cycle's operation |
| out_int | output | 32 | Integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Denormal-input flag |

## Verification
The hardest cases to reach are where rounding carries an in-range value across a limit. Examples are a negative fraction between one half and one that rounds to magnitude one in unsigned mode, and magnitudes exactly at 2^31 that sit on the signed clamp boundary. The stimulus hits these with hand-picked encodings (-0.75, ±2^31, the largest value below 2^32). Ties at exactly one half are applied to both even and odd integer parts. Each value is tried in more than one rounding mode, with and without force-truncate. The operations are sent back to back and also with idle gaps, so the scoreboard also checks result ordering and the valid timing.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_UP      = 2'd1,
    RND_DOWN    = 2'd2,
    RND_ZERO    = 2'd3
  } rnd_e;

  typedef enum logic [2:0] {
    CLS_ZERO  = 3'd0,
    CLS_SMALL = 3'd1,
    CLS_RANGE = 3'd2,
    CLS_HUGE  = 3'd3,
    CLS_NAN   = 3'd4
  } cls_e;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int FP_W  = 1 + EXP_W + FRAC_W,
  localparam int SH_W  = $clog2(INT_W + 1)
) (
  input  logic [FP_W-1:0]  op,
  output logic             sign,
  output cls_e             cls,
  output logic             denorm,
  output logic [INT_W-1:0] mant,
  output logic [SH_W-1:0]  shift
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_LO = BIAS - 1;
  localparam int EXP_HI = BIAS + INT_W - 1;
  localparam int PAD_W  = INT_W - 1 - FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign   = op[FP_W-1];
  assign exp_f  = op[FP_W-2 -: EXP_W];
  assign frac_f = op[FRAC_W-1:0];
  assign denorm = (exp_f == '0) && (frac_f != '0);

  // Significand left-aligned in the integer width; implicit one on top.
  assign mant = {(exp_f != '0), frac_f, {PAD_W{1'b0}}};

  always_comb begin
    shift = '0;
    if (int'(exp_f) >= EXP_LO && int'(exp_f) <= EXP_HI)
      shift = SH_W'(EXP_HI - int'(exp_f));
  end

  always_comb begin
    if (exp_f == '1 && frac_f != '0)      cls = CLS_NAN;
    else if (int'(exp_f) > EXP_HI)        cls = CLS_HUGE;
    else if (int'(exp_f) >= EXP_LO)       cls = CLS_RANGE;
    else if (exp_f == '0 && frac_f == '0) cls = CLS_ZERO;
    else                                  cls = CLS_SMALL;
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32,
  localparam int SH_W = $clog2(INT_W + 1)
) (
  input  logic [INT_W-1:0] mant,
  input  logic [SH_W-1:0]  shift,
  input  logic             sign,
  input  rnd_e             mode,
  output logic [INT_W-1:0] ipart,
  output logic             rem_nz,
  output logic             carry
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  logic [2*INT_W-1:0] wide;
  logic [INT_W-1:0]   rem;

  assign wide   = {mant, {INT_W{1'b0}}} >> shift;
  assign ipart  = wide[2*INT_W-1:INT_W];
  assign rem    = wide[INT_W-1:0];
  assign rem_nz = (rem != '0);

  always_comb begin
    unique case (mode)
      RND_NEAREST: carry = (rem > HALF) || (rem == HALF && ipart[0]);
      RND_UP:      carry = !sign && rem_nz;
      RND_DOWN:    carry = sign && rem_nz;
      default:     carry = 1'b0;
    endcase
  end
endmodule

// File: rtl/f2i_resolve.sv
module f2i_resolve
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  cls_e             cls,
  input  logic             sign,
  input  logic             is_signed,
  input  rnd_e             mode,
  input  logic [INT_W-1:0] ipart,
  input  logic             rem_nz,
  input  logic             carry,
  output logic [INT_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [INT_W-1:0] bumped, limit, mag;
  logic             top_carry;

  assign top_carry = carry && (ipart == '1);
  assign bumped    = (carry && !top_carry) ? ipart + 1'b1 : ipart;
  assign limit     = POS_MAX + INT_W'(sign);

  always_comb begin
    result  = '0;
    invalid = 1'b0;
    inexact = 1'b0;
    mag     = '0;
    unique case (cls)
      CLS_NAN: begin
        invalid = 1'b1;
        result  = is_signed ? '0 : '1;
      end
      CLS_HUGE: begin
        invalid = 1'b1;
        if (is_signed) result = sign ? NEG_MIN : POS_MAX;
        else           result = sign ? '0 : '1;
      end
      CLS_RANGE: begin
        if (!is_signed) begin
          invalid = top_carry;
          if (sign && bumped != '0) begin
            invalid = 1'b1;
          end else begin
            result  = bumped;
            inexact = rem_nz;
          end
        end else begin
          if (bumped > limit) begin
            mag     = limit;
            invalid = 1'b1;
          end else begin
            mag     = bumped;
            inexact = rem_nz;
          end
          result = sign ? (~mag + 1'b1) : mag;
        end
      end
      CLS_SMALL: begin
        inexact = 1'b1;
        if (mode == RND_UP && !sign) begin
          result = INT_W'(1);
        end else if (mode == RND_DOWN && sign) begin
          if (is_signed) result = '1;
          else           invalid = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int FP_W  = 1 + EXP_W + FRAC_W,
  localparam int SH_W  = $clog2(INT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  in_bits,
  input  logic             to_signed,
  input  logic [1:0]       round_mode,
  input  logic             force_trunc,
  output logic             out_valid,
  output logic [INT_W-1:0] out_int,
  output logic             out_invalid,
  output logic             out_inexact,
  output logic             out_denorm
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_HI = BIAS + INT_W - 1;

  rnd_e             eff_mode;
  cls_e             cls;
  logic             sign, denorm, rem_nz, carry, invalid, inexact;
  logic [INT_W-1:0] mant, ipart, result;
  logic [SH_W-1:0]  shift;

  assign eff_mode = force_trunc ? RND_ZERO : rnd_e'(round_mode);

  f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_classify (
    .op(in_bits), .sign(sign), .cls(cls), .denorm(denorm),
    .mant(mant), .shift(shift)
  );

  f2i_round #(.INT_W(INT_W)) u_round (
    .mant(mant), .shift(shift), .sign(sign), .mode(eff_mode),
    .ipart(ipart), .rem_nz(rem_nz), .carry(carry)
  );

  f2i_resolve #(.INT_W(INT_W)) u_resolve (
    .cls(cls), .sign(sign), .is_signed(to_signed), .mode(eff_mode),
    .ipart(ipart), .rem_nz(rem_nz), .carry(carry),
    .result(result), .invalid(invalid), .inexact(inexact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_denorm  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= result;
        out_invalid <= invalid;
        out_inexact <= inexact;
        out_denorm  <= denorm;
      end
    end
  end

  // Operand fields seen directly at the port, for the checks below.
  logic [EXP_W-1:0]  a_exp;
  logic [FRAC_W-1:0] a_frac;
  logic              a_sign;
  assign a_exp  = in_bits[FP_W-2 -: EXP_W];
  assign a_frac = in_bits[FRAC_W-1:0];
  assign a_sign = in_bits[FP_W-1];

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_zero_clean_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_exp == '0 && a_frac == '0) |=>
      (out_int == '0 && !out_invalid && !out_inexact && !out_denorm));
  assert_nan_signed_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && to_signed && a_exp == '1 && a_frac != '0) |=>
      (out_int == '0 && out_invalid));
  assert_huge_unsigned_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !to_signed && int'(a_exp) > EXP_HI && !a_sign) |=>
      (out_int == '1 && out_invalid));
  assert_denorm_flag_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_denorm == $past(a_exp == '0 && a_frac != '0)));
endmodule

// File: tb/f2i_convert_bench.sv
module f2i_convert_bench;
  typedef struct {
    logic [31:0] val;
    logic        inv;
    logic        inx;
    logic        den;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = '0;
  logic        to_signed = 1'b0;
  logic [1:0]  round_mode = 2'd0;
  logic        force_trunc = 1'b0;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_invalid, out_inexact, out_denorm;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  f2i_convert u_f2i_convert (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
    .to_signed(to_signed), .round_mode(round_mode), .force_trunc(force_trunc),
    .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_denorm(out_denorm)
  );

  task automatic send(input logic [31:0] b, input logic s, input logic [1:0] rm,
                      input logic ft, input logic [31:0] ev, input logic einv,
                      input logic einx, input logic eden, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid    = 1'b1;
    in_bits     = b;
    to_signed   = s;
    round_mode  = rm;
    force_trunc = ft;
    e.val = ev; e.inv = einv; e.inx = einx; e.den = eden; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL R1 unexpected result: actual=%08h expected=none", out_int);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_int !== e.val || out_invalid !== e.inv ||
            out_inexact !== e.inx || out_denorm !== e.den) begin
          n_fails++;
          $display("FAIL %s: actual=%08h inv=%b inx=%b den=%b expected=%08h inv=%b inx=%b den=%b",
                   e.tag, out_int, out_invalid, out_inexact, out_denorm,
                   e.val, e.inv, e.inx, e.den);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    n_checks++;
    if (out_valid !== 1'b0 || out_int !== 32'h0 || out_invalid !== 1'b0 ||
        out_inexact !== 1'b0 || out_denorm !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 reset: actual=%b/%08h expected=0/00000000", out_valid, out_int);
    end

    // R3 in-range rounding
    send(32'h3F800000, 0, 2'd0, 0, 32'd1,          0, 0, 0, "R3 1.0 unsigned");
    send(32'h40200000, 0, 2'd0, 0, 32'd2,          0, 1, 0, "R3 2.5 nearest tie even");
    send(32'h40600000, 1, 2'd0, 0, 32'd4,          0, 1, 0, "R3 3.5 nearest tie odd");
    send(32'h3F000000, 0, 2'd0, 0, 32'd0,          0, 1, 0, "R3 0.5 nearest");
    send(32'h3FC00000, 0, 2'd0, 0, 32'd2,          0, 1, 0, "R3 1.5 nearest");
    send(32'h4F7FFFFF, 0, 2'd0, 0, 32'hFFFFFF00,   0, 0, 0, "R3 largest below 2^32");
    idle(2);
    // R2 modes and override
    send(32'h40200000, 0, 2'd1, 0, 32'd3,          0, 1, 0, "R2 2.5 up");
    send(32'h40200000, 0, 2'd1, 1, 32'd2,          0, 1, 0, "R2 2.5 up forced trunc");
    send(32'hC0200000, 1, 2'd0, 0, 32'hFFFFFFFE,   0, 1, 0, "R2 -2.5 nearest");
    send(32'hC0200000, 1, 2'd2, 0, 32'hFFFFFFFD,   0, 1, 0, "R2 -2.5 down");
    send(32'hC0200000, 1, 2'd1, 0, 32'hFFFFFFFE,   0, 1, 0, "R2 -2.5 up");
    send(32'hC0200000, 1, 2'd3, 0, 32'hFFFFFFFE,   0, 1, 0, "R2 -2.5 zero");
    send(32'hC0200000, 1, 2'd2, 1, 32'hFFFFFFFE,   0, 1, 0, "R2 -2.5 down forced trunc");
    idle(1);
    // R4 / R5 out of range
    send(32'h4F800000, 0, 2'd0, 0, 32'hFFFFFFFF,   1, 0, 0, "R4 2^32 unsigned");
    send(32'hCF800000, 0, 2'd0, 0, 32'h00000000,   1, 0, 0, "R4 -2^32 unsigned");
    send(32'h7F800000, 0, 2'd0, 0, 32'hFFFFFFFF,   1, 0, 0, "R4 +inf unsigned");
    send(32'hFF800000, 0, 2'd1, 0, 32'h00000000,   1, 0, 0, "R4 -inf unsigned");
    send(32'h4F800000, 1, 2'd0, 0, 32'h7FFFFFFF,   1, 0, 0, "R5 2^32 signed");
    send(32'hCF800000, 1, 2'd0, 0, 32'h80000000,   1, 0, 0, "R5 -2^32 signed");
    send(32'hFF800000, 1, 2'd3, 0, 32'h80000000,   1, 0, 0, "R5 -inf signed");
    // R6 NaN
    send(32'h7FC00000, 1, 2'd0, 0, 32'h00000000,   1, 0, 0, "R6 qnan signed");
    send(32'h7F800001, 1, 2'd1, 0, 32'h00000000,   1, 0, 0, "R6 snan signed");
    send(32'h7FC00000, 0, 2'd0, 0, 32'hFFFFFFFF,   1, 0, 0, "R6 qnan unsigned");
    send(32'hFFC00000, 0, 2'd2, 0, 32'hFFFFFFFF,   1, 0, 0, "R6 negative nan unsigned");
    idle(3);
    // R7 unsigned negatives
    send(32'hBF400000, 0, 2'd0, 0, 32'h00000000,   1, 0, 0, "R7 -0.75 nearest unsigned");
    send(32'hBF400000, 0, 2'd3, 0, 32'h00000000,   0, 1, 0, "R7 -0.75 zero unsigned");
    send(32'hC0200000, 0, 2'd3, 0, 32'h00000000,   1, 0, 0, "R7 -2.5 zero unsigned");
    // R8 signed clamp
    send(32'h4F000000, 1, 2'd0, 0, 32'h7FFFFFFF,   1, 0, 0, "R8 2^31 signed");
    send(32'hCF000000, 1, 2'd0, 0, 32'h80000000,   0, 0, 0, "R8 -2^31 signed");
    send(32'h4F000000, 0, 2'd0, 0, 32'h80000000,   0, 0, 0, "R8 2^31 unsigned");
    send(32'hBF400000, 1, 2'd0, 0, 32'hFFFFFFFF,   0, 1, 0, "R8 -0.75 nearest signed");
    // R9 small magnitudes
    send(32'h3E800000, 0, 2'd0, 0, 32'h00000000,   0, 1, 0, "R9 0.25 nearest");
    send(32'h3E800000, 0, 2'd1, 0, 32'h00000001,   0, 1, 0, "R9 0.25 up");
    send(32'h3E800000, 0, 2'd1, 1, 32'h00000000,   0, 1, 0, "R9 0.25 up forced trunc");
    send(32'hBE800000, 1, 2'd2, 0, 32'hFFFFFFFF,   0, 1, 0, "R9 -0.25 down signed");
    send(32'hBE800000, 0, 2'd2, 0, 32'h00000000,   1, 1, 0, "R9 -0.25 down unsigned");
    send(32'hBE800000, 1, 2'd1, 0, 32'h00000000,   0, 1, 0, "R9 -0.25 up signed");
    send(32'h3E800000, 1, 2'd2, 0, 32'h00000000,   0, 1, 0, "R9 0.25 down signed");
    // R10 zeros
    send(32'h00000000, 1, 2'd0, 0, 32'h00000000,   0, 0, 0, "R10 +0 signed");
    send(32'h80000000, 0, 2'd2, 0, 32'h00000000,   0, 0, 0, "R10 -0 unsigned down");
    send(32'h80000000, 1, 2'd1, 0, 32'h00000000,   0, 0, 0, "R10 -0 signed up");
    // R11 denormals
    send(32'h00000001, 0, 2'd0, 0, 32'h00000000,   0, 1, 1, "R11 tiny denormal");
    send(32'h00000001, 1, 2'd1, 0, 32'h00000001,   0, 1, 1, "R11 denormal up");
    send(32'h807FFFFF, 1, 2'd2, 0, 32'hFFFFFFFF,   0, 1, 1, "R11 negative denormal down");
    idle(4);

    // R1 idle: no result without an operation, scoreboard drained
    n_checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R1 drain: actual=valid %b pending %0d expected=valid 0 pending 0",
               out_valid, exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule